// File: doc/BRIEF.md
# Integer/FP Dual-Issue Pair Checker

This block sits at the issue point of a two-wide in-order pipeline. Fetch delivers instructions as an aligned pair. The first slot is the integer side: an ALU operation, branch, load, store, or an FP register transfer. The second slot is the floating-point side. Each cycle the block decodes the primary opcode of both instructions and compares register fields inside the pair. It then either issues both instructions together, or issues the first alone and splits the pair.

On a split, the second instruction is kept in a one-entry hold register. It issues alone in the first slot of the next cycle. During that cycle the pair on the inputs is not accepted, and fetch keeps presenting it until the acknowledge rises.

A parameter selects the register-file variant. Without extra FP register ports, any FP load, store or transfer paired with an FP operation counts as a port conflict. With extra ports, only a true read-after-write inside the pair splits it. Hazards against older instructions are handled elsewhere.

Top module: `dual_issue_pair`

## Requirements
- R1: The opcode is bits 31:26 and is decoded as follows:
  - 0x00 and 0x08–0x0F: integer ALU.
  - 0x02–0x05: branch or jump.
  - 0x20–0x27: integer load.
  - 0x28–0x2F: integer store.
  - 0x30: FP load.
  - 0x31: FP store.
  - 0x32: move integer to FP.
  - 0x33: move FP to integer.
  - 0x01: FP operation.
  - Any other value: unpairable.
  
  A valid pair whose first slot is in the integer group (every class above except FP operation and unpairable) and whose second slot is an FP operation, with no hazard, issues both slots in the same cycle. That cycle raises acknowledge and presents the two instructions on the slot outputs.
- R2: Slot 1 never issues in a cycle in which slot 0 does not issue.
- R3: A pair that breaks the integer-first, FP-second pattern is split. The first instruction issues alone with split and acknowledge high, and the second follows alone in the next cycle.
- R4: A branch or any memory reference (integer or FP load or store) in the second slot always splits the pair. As a result, at most one memory reference and no second-slot branch issue per cycle.
- R5: In both variants, the pair is split when the first slot is an FP load or a move to FP and its destination (bits 20:16) equals either source of the FP operation (bits 25:21 or 20:16).
- R6: With EXTRA_FP_PORTS=0, an FP load, FP store, move to FP or move from FP in the first slot always splits a pair whose second slot is an FP operation.
- R7: With EXTRA_FP_PORTS=1, those same pairs issue together when R5 does not apply. This includes an FP store or a move from FP whose register fields match the FP operation's sources, and an FP load whose destination equals only the FP operation's destination (bits 15:11).
- R8: In the cycle after a split, only slot 0 issues, carrying the held second instruction. Acknowledge and split stay low, and the input pair is ignored.
- R9: Reset empties the hold register. A hold pending when reset asserts never issues.
- R10: With pair_valid_i low and nothing held, nothing issues and acknowledge stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pair_valid_i | input | 1 | An aligned pair is presented |
| inst0_i | input | 32 | First (integer-side) instruction |
| inst1_i | input | 32 | Second (FP-side) instruction |
| pair_ack_o | output | 1 | Pair accepted this cycle; fetch may advance |
| slot0_issue_o | output | 1 | Slot 0 issues this cycle |
| slot1_issue_o | output | 1 | Slot 1 issues this cycle |
| split_o | output | 1 | Pair split; second instruction held for next cycle |
| slot0_inst_o | output | 32 | Instruction issued in slot 0, zero when idle |
| slot1_inst_o | output | 32 | Instruction issued in slot 1, zero when idle |

## Verification
The only internal state is the hold entry. A fault there shows at the ports in the cycle right after a split.

If the hold is lost, the second instruction never appears on slot 0. Acknowledge then rises a cycle early, which drops an instruction. If the hold sticks, acknowledge stays low and the same instruction issues repeatedly.

A wrong decode or register compare shows in the same cycle as a wrong split or slot-1 issue. The reference model runs both register-port variants side by side, so a rule that leaks from one variant into the other shows as a mismatch in that cycle.

// File: rtl/dual_issue_pkg.sv
package dual_issue_pkg;
  localparam int INST_W    = 32;
  localparam int OP_W      = 6;
  localparam int REG_W     = 5;
  localparam int OP_LSB    = INST_W - OP_W;
  localparam int SRC_A_LSB = OP_LSB - REG_W;
  localparam int SRC_B_LSB = SRC_A_LSB - REG_W;
  localparam int N_SLOTS   = 2;

  typedef enum logic [3:0] {
    CL_INT, CL_BR, CL_LD, CL_ST, CL_FLD, CL_FST, CL_MTF, CL_MFF, CL_FOP, CL_OTH
  } op_class_e;
endpackage

// File: rtl/pair_op_decode.sv
module pair_op_decode
  import dual_issue_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output op_class_e       cls_o
);
  always_comb begin
    case (op_i) inside
      6'h00, [6'h08:6'h0F]: cls_o = CL_INT;
      [6'h02:6'h05]:        cls_o = CL_BR;
      [6'h20:6'h27]:        cls_o = CL_LD;
      [6'h28:6'h2F]:        cls_o = CL_ST;
      6'h30:                cls_o = CL_FLD;
      6'h31:                cls_o = CL_FST;
      6'h32:                cls_o = CL_MTF;
      6'h33:                cls_o = CL_MFF;
      6'h01:                cls_o = CL_FOP;
      default:              cls_o = CL_OTH;
    endcase
  end
endmodule

// File: rtl/pair_issue_rules.sv
module pair_issue_rules
  import dual_issue_pkg::*;
#(
  parameter bit EXTRA_FP_PORTS = 1'b0
) (
  input  op_class_e        cls0_i,
  input  op_class_e        cls1_i,
  input  logic [REG_W-1:0] dst0_i,
  input  logic [REG_W-1:0] srca1_i,
  input  logic [REG_W-1:0] srcb1_i,
  output logic             split_req_o
);
  logic pattern_ok, writes_fp0, raw_hit, port_block;

  assign pattern_ok = (cls0_i inside {CL_INT, CL_BR, CL_LD, CL_ST,
                                      CL_FLD, CL_FST, CL_MTF, CL_MFF})
                      && (cls1_i == CL_FOP);
  assign writes_fp0 = cls0_i inside {CL_FLD, CL_MTF};
  assign raw_hit    = writes_fp0 && ((dst0_i == srca1_i) || (dst0_i == srcb1_i));

  generate
    if (EXTRA_FP_PORTS) begin : g_extra_ports
      assign port_block = 1'b0;
    end else begin : g_shared_ports
      // FP transfer in slot 0 competes with the FP op for register ports
      assign port_block = cls0_i inside {CL_FLD, CL_FST, CL_MTF, CL_MFF};
    end
  endgenerate

  assign split_req_o = !pattern_ok || raw_hit || port_block;
endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
  import dual_issue_pkg::*;
#(
  parameter bit EXTRA_FP_PORTS = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pair_valid_i,
  input  logic [INST_W-1:0] inst0_i,
  input  logic [INST_W-1:0] inst1_i,
  output logic              pair_ack_o,
  output logic              slot0_issue_o,
  output logic              slot1_issue_o,
  output logic              split_o,
  output logic [INST_W-1:0] slot0_inst_o,
  output logic [INST_W-1:0] slot1_inst_o
);
  logic [INST_W-1:0] slot_inst [N_SLOTS];
  op_class_e         cls       [N_SLOTS];
  logic              split_req;
  logic              held_v_q;
  logic [INST_W-1:0] held_inst_q;
  logic              fresh;

  assign slot_inst[0] = inst0_i;
  assign slot_inst[1] = inst1_i;

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_dec
    pair_op_decode u_dec (
      .op_i  (slot_inst[g][INST_W-1:OP_LSB]),
      .cls_o (cls[g])
    );
  end

  pair_issue_rules #(.EXTRA_FP_PORTS(EXTRA_FP_PORTS)) u_rules (
    .cls0_i      (cls[0]),
    .cls1_i      (cls[1]),
    .dst0_i      (inst0_i[SRC_B_LSB +: REG_W]),
    .srca1_i     (inst1_i[SRC_A_LSB +: REG_W]),
    .srcb1_i     (inst1_i[SRC_B_LSB +: REG_W]),
    .split_req_o (split_req)
  );

  // a held instruction always drains alone before a new pair is accepted
  assign fresh         = pair_valid_i && !held_v_q;
  assign pair_ack_o    = fresh;
  assign slot0_issue_o = held_v_q || pair_valid_i;
  assign slot1_issue_o = fresh && !split_req;
  assign split_o       = fresh && split_req;
  assign slot0_inst_o  = held_v_q ? held_inst_q : (pair_valid_i ? inst0_i : '0);
  assign slot1_inst_o  = slot1_issue_o ? inst1_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_v_q    <= 1'b0;
      held_inst_q <= '0;
    end else if (split_o) begin
      held_v_q    <= 1'b1;
      held_inst_q <= inst1_i;
    end else begin
      held_v_q    <= 1'b0;
    end
  end

  p_slot1_needs_slot0_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot1_issue_o |-> slot0_issue_o);

  p_split_alone_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    split_o |-> (slot0_issue_o && !slot1_issue_o && pair_ack_o));

  p_slot1_fp_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot1_issue_o |-> (cls[1] == CL_FOP));

  p_raw_blocks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fresh && (cls[0] inside {CL_FLD, CL_MTF})
     && (inst0_i[SRC_B_LSB +: REG_W] == inst1_i[SRC_A_LSB +: REG_W]))
    |-> !slot1_issue_o);

  p_held_next_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    split_o |=> (slot0_issue_o && !slot1_issue_o && !pair_ack_o
                 && (slot0_inst_o == $past(inst1_i))));

  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pair_valid_i && !held_v_q) |-> (!slot0_issue_o && !pair_ack_o));

  if (!EXTRA_FP_PORTS) begin : g_chk_shared
    p_no_port_pair_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slot1_issue_o |-> !(cls[0] inside {CL_FLD, CL_FST, CL_MTF, CL_MFF}));
  end
endmodule

// File: tb/test_dual_issue_pair.sv
`timescale 1ns/1ps
module test_dual_issue_pair;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, vld;
  logic [31:0] in0, in1;
  logic        s0 [2], s1 [2], sp [2], ack [2];
  logic [31:0] o0 [2], o1 [2];

  int total = 0, bad = 0;
  bit done = 0;

  logic        mh_v [2];
  logic [31:0] mh_i [2];

  dual_issue_pair #(.EXTRA_FP_PORTS(1'b0)) i_dual_issue_pair (
    .clk_i(clk), .rst_ni(rst_n), .pair_valid_i(vld), .inst0_i(in0), .inst1_i(in1),
    .pair_ack_o(ack[0]), .slot0_issue_o(s0[0]), .slot1_issue_o(s1[0]), .split_o(sp[0]),
    .slot0_inst_o(o0[0]), .slot1_inst_o(o1[0]));

  dual_issue_pair #(.EXTRA_FP_PORTS(1'b1)) i_dual_issue_pair_xp (
    .clk_i(clk), .rst_ni(rst_n), .pair_valid_i(vld), .inst0_i(in0), .inst1_i(in1),
    .pair_ack_o(ack[1]), .slot0_issue_o(s0[1]), .slot1_issue_o(s1[1]), .split_o(sp[1]),
    .slot0_inst_o(o0[1]), .slot1_inst_o(o1[1]));

  localparam logic [5:0] OP_INT = 6'h00, OP_IMM = 6'h0C, OP_BR = 6'h04, OP_LD = 6'h23,
                         OP_ST = 6'h2B, OP_FLD = 6'h30, OP_FST = 6'h31, OP_MTF = 6'h32,
                         OP_MFF = 6'h33, OP_FOP = 6'h01, OP_BAD = 6'h3F;

  function automatic logic [31:0] mk(input logic [5:0] op, input int a, input int b, input int c);
    return {op, a[4:0], b[4:0], c[4:0], 11'h000};
  endfunction

  // 0 int,1 br,2 ld,3 st,4 fld,5 fst,6 mtf,7 mff,8 fop,9 other
  function automatic int kind(input logic [5:0] op);
    if (op == 6'h00 || (op >= 6'h08 && op <= 6'h0F)) return 0;
    if (op >= 6'h02 && op <= 6'h05) return 1;
    if (op >= 6'h20 && op <= 6'h27) return 2;
    if (op >= 6'h28 && op <= 6'h2F) return 3;
    if (op == 6'h30) return 4;
    if (op == 6'h31) return 5;
    if (op == 6'h32) return 6;
    if (op == 6'h33) return 7;
    if (op == 6'h01) return 8;
    return 9;
  endfunction

  task automatic chk(input int k, input bit xp, input string tag);
    logic e0, e1, esp, eack, raw, brk;
    logic [31:0] ei0, ei1;
    int c0, c1;
    e0 = 0; e1 = 0; esp = 0; eack = 0; ei0 = '0; ei1 = '0;
    if (mh_v[k]) begin
      e0 = 1; ei0 = mh_i[k]; mh_v[k] = 0;
    end else if (vld) begin
      c0  = kind(in0[31:26]);
      c1  = kind(in1[31:26]);
      raw = (c0 == 4 || c0 == 6) && (in0[20:16] == in1[25:21] || in0[20:16] == in1[20:16]);
      brk = !(c0 <= 7 && c1 == 8) || raw || (!xp && c0 >= 4 && c0 <= 7);
      e0 = 1; ei0 = in0; eack = 1; esp = brk; e1 = !brk; ei1 = in1;
      if (brk) begin mh_v[k] = 1; mh_i[k] = in1; end
    end
    total++;
    if ({s0[k], s1[k], sp[k], ack[k]} !== {e0, e1, esp, eack}
        || (e0 && o0[k] !== ei0) || (e1 && o1[k] !== ei1)) begin
      bad++;
      $display("FAIL %s dut%0d flags act=%b exp=%b inst0 act=%h exp=%h inst1 act=%h exp=%h",
               tag, k, {s0[k], s1[k], sp[k], ack[k]}, {e0, e1, esp, eack},
               o0[k], ei0, o1[k], ei1);
    end
    total++;
    if (s1[k] === 1'b1 && s0[k] !== 1'b1) begin
      bad++;
      $display("FAIL R2 dut%0d slot1 without slot0 act=%b%b exp=11", k, s0[k], s1[k]);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] a, input logic [31:0] b, input string tag);
    @(negedge clk);
    vld = v; in0 = a; in1 = b;
    #2;
    if (!rst_n) begin mh_v[0] = 0; mh_v[1] = 0; end
    chk(0, 1'b0, tag);
    chk(1, 1'b1, tag);
  endtask

  task automatic run(input logic [31:0] a, input logic [31:0] b, input string tag);
    step(1'b1, a, b, tag);
    step(1'b0, '0, '0, "R8");
  endtask

  initial begin
    mh_v[0] = 0; mh_v[1] = 0; mh_i[0] = '0; mh_i[1] = '0;
    rst_n = 0; vld = 0; in0 = '0; in1 = '0;
    step(1'b0, '0, '0, "R9");
    step(1'b0, '0, '0, "R9");
    rst_n = 1;
    step(1'b0, mk(OP_INT, 1, 2, 3), mk(OP_FOP, 1, 2, 3), "R10");

    run(mk(OP_INT, 1, 2, 3), mk(OP_FOP, 1, 2, 4), "R1");
    run(mk(OP_LD, 4, 5, 0), mk(OP_FOP, 5, 6, 7), "R1");
    run(mk(OP_BR, 1, 0, 0), mk(OP_FOP, 2, 3, 4), "R1");
    run(mk(OP_ST, 2, 9, 0), mk(OP_FOP, 9, 9, 9), "R1");
    run(mk(OP_IMM, 3, 3, 0), mk(OP_FOP, 3, 3, 3), "R1");

    run(mk(OP_FOP, 1, 2, 3), mk(OP_FOP, 4, 5, 6), "R3");
    run(mk(OP_INT, 1, 2, 3), mk(OP_INT, 4, 5, 6), "R3");
    run(mk(OP_BAD, 1, 2, 3), mk(OP_FOP, 4, 5, 6), "R3");
    run(mk(OP_FOP, 1, 2, 3), mk(OP_IMM, 4, 5, 6), "R3");

    run(mk(OP_INT, 1, 2, 3), mk(OP_BR, 4, 5, 6), "R4");
    run(mk(OP_INT, 1, 2, 3), mk(OP_LD, 4, 5, 6), "R4");
    run(mk(OP_ST, 1, 2, 3), mk(OP_FST, 4, 5, 6), "R4");

    run(mk(OP_FLD, 1, 3, 0), mk(OP_FOP, 3, 4, 5), "R5");
    run(mk(OP_MTF, 1, 5, 0), mk(OP_FOP, 2, 5, 6), "R5");

    run(mk(OP_FST, 1, 2, 0), mk(OP_FOP, 2, 2, 4), "R6 R7");
    run(mk(OP_MFF, 2, 8, 0), mk(OP_FOP, 2, 8, 1), "R6 R7");
    run(mk(OP_FLD, 1, 7, 0), mk(OP_FOP, 1, 2, 7), "R6 R7");
    run(mk(OP_MTF, 4, 9, 0), mk(OP_FOP, 1, 2, 3), "R6 R7");

    // input pair presented during a hold must be ignored
    step(1'b1, mk(OP_FOP, 1, 2, 3), mk(OP_FOP, 4, 5, 6), "R3");
    step(1'b1, mk(OP_INT, 7, 7, 7), mk(OP_FOP, 8, 8, 8), "R8");
    step(1'b1, mk(OP_INT, 7, 7, 7), mk(OP_FOP, 8, 8, 8), "R1");
    step(1'b0, '0, '0, "R10");

    // hold pending at reset never issues
    step(1'b1, mk(OP_INT, 1, 1, 1), mk(OP_LD, 2, 2, 2), "R4");
    @(negedge clk); rst_n = 0; mh_v[0] = 0; mh_v[1] = 0;
    step(1'b0, '0, '0, "R9");
    rst_n = 1;
    step(1'b0, '0, '0, "R9");

    for (int n = 0; n < 400; n++) begin
      logic [5:0] ops [11];
      ops = '{OP_INT, OP_IMM, OP_BR, OP_LD, OP_ST, OP_FLD, OP_FST, OP_MTF, OP_MFF, OP_FOP, OP_BAD};
      step(1'($urandom_range(0, 3) != 0),
           mk(ops[$urandom_range(0, 10)], $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3)),
           mk(($urandom_range(0, 2) != 0) ? OP_FOP : ops[$urandom_range(0, 10)],
              $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3)),
           "R1");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL R10 watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule